// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer whose four control registers can only be changed after a key sequence has been written to a matching lock register. Each control register has its own lock. A lock opens only when the exact key words arrive in the right order. Its progress can be read back in the low two bits of that lock register. An open lock allows exactly one write to the register it guards.

The timer divides the clock by a programmable prescale value. It then counts a programmable reload value down to zero. When the count expires while the timer is running, the block raises a one-cycle reset pulse and starts the count again. Software keeps the system alive by restarting the count (a kick) before it expires. Software can also stop and start the timer, but only through the longest key sequence, which has three keys.

The register bus is a simple single-cycle write port with a combinational read port. Both share one 3-bit address. Lock registers sit at addresses 0 to 3. The register that the lock at address a guards sits at address a+4.

Top module: `wdg_lockbank`

## Requirements
- R1: After reset all lock registers read 0, the reload register reads 0xFFFF, the prescale register reads 0, the run register reads 0, the kick register reads 0 and `wdog_rst` is low.
- R2: The address map is: addr 0 kick lock, addr 1 reload lock, addr 2 prescale lock, addr 3 run lock, and addr 4/5/6/7 the kick, reload, prescale and run registers. The three two-key locks use these keys: kick lock 0x5555 then 0xAAAA; reload lock 0x6666 then 0xBBBB; prescale lock 0x5A5A then 0xA5A5. The low two bits of a two-key lock read 1 after its first key and 3 once it is open.
- R3: The run lock opens with the keys 0x7777, 0xCCCC and 0xDDDD, in that order. Its low two bits read 1, 2 and then 3 as each key is accepted.
- R4: Any lock write that is not the next expected key returns that lock to 0. This includes a write to a lock that is already open and a key sent out of order.
- R5: A write to a guarded register whose lock is not open is ignored. The stored value does not change and the lock progress does not change.
- R6: An accepted write to a guarded register returns its lock to 0. A second write to the same register without a new key sequence is ignored.
- R7: An accepted run write with bit 0 set starts the timer. It loads the counter from the reload value and clears the prescaler. An accepted run write with bit 0 clear stops the timer, and no pulse appears while the timer is stopped.
- R8: With reload value R and prescale value P, the first pulse appears (R+1)*(P+1) clock edges after the start write. Further pulses follow at the same period. Each pulse lasts exactly one clock cycle.
- R9: An accepted kick write of value 1 restarts the count in the same way as a start. If the kick lands on the same edge on which the count would expire, the kick wins and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Register address for both reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| wdog_rst | output | 1 | One-cycle reset pulse when the count expires |

## Verification
Two events can land on the same clock edge: an accepted kick and the natural expiry of the count. The bench programs a reload value of 5 and a prescale value of 1, which gives a 12-edge period. It starts the timer and opens the kick lock during the next two cycles. It then times the kick write so that it lands exactly on the twelfth edge. The design is correct if no pulse appears after that edge and the next pulse appears a full period after the kick. A separate run with no kick confirms that this same edge would otherwise have produced a pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic [1:0] {
      SEL_KICK   = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_PRESC  = 2'd2,
      SEL_RUN    = 2'd3
   } wdg_sel_e;

   localparam int NUM_GUARDS = 4;

   function automatic int nkeys_of(input int g);
      return (g == int'(SEL_RUN)) ? 3 : 2;
   endfunction

   function automatic logic [15:0] key_of(input int g, input int n);
      logic [15:0] k;
      k = 16'h0000;
      case (g)
         0: k = (n == 0) ? 16'h5555 : 16'hAAAA;
         1: k = (n == 0) ? 16'h6666 : 16'hBBBB;
         2: k = (n == 0) ? 16'h5A5A : 16'hA5A5;
         default: k = (n == 0) ? 16'h7777 : ((n == 1) ? 16'hCCCC : 16'hDDDD);
      endcase
      return k;
   endfunction

endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
   parameter int DATA_W   = 16,
   parameter int NUM_KEYS = 2,
   parameter logic [DATA_W-1:0] KEY0 = '0,
   parameter logic [DATA_W-1:0] KEY1 = '0,
   parameter logic [DATA_W-1:0] KEY2 = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_wr,
   input  logic              guard_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              accept,
   output logic              is_open,
   output logic [1:0]        prog
);

   localparam logic [1:0] OPEN_STEP = 2'(NUM_KEYS);

   generate
      if (NUM_KEYS != 2 && NUM_KEYS != 3) begin : g_bad_keys
         $error("wdg_key_gate: NUM_KEYS must be 2 or 3");
      end
   endgenerate

   logic [1:0]        step_q;
   logic [DATA_W-1:0] want;

   always_comb begin
      case (step_q)
         2'd0:    want = KEY0;
         2'd1:    want = KEY1;
         default: want = KEY2;
      endcase
   end

   assign is_open = (step_q == OPEN_STEP);
   assign accept  = guard_wr && is_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= 2'd0;
      end else if (lock_wr) begin
         if (!is_open && wdata == want) step_q <= step_q + 2'd1;
         else                           step_q <= 2'd0;
      end else if (accept) begin
         step_q <= 2'd0;
      end
   end

   generate
      if (NUM_KEYS == 3) begin : g_prog_linear
         assign prog = step_q;
      end else begin : g_prog_jump
         assign prog = (step_q == 2'd2) ? 2'd3 : step_q;
      end
   endgenerate

   AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      step_q <= OPEN_STEP);  // R3

   AST_WRONG_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && (is_open || wdata != want)) |=> (prog == 2'd0));  // R4

   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !lock_wr) |=> !is_open);  // R6

   AST_IGNORED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_wr && !is_open && !lock_wr) |=> $stable(step_q));  // R5

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
   parameter int CNT_W = 16,
   parameter int PRE_W = 16,
   parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [CNT_W-1:0] reload,
   input  logic [PRE_W-1:0] presc,
   output logic             expire
);

   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fire_q;
   logic             tick;

   assign tick   = (pre_q == presc);
   assign expire = fire_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         cnt_q  <= RELOAD_INIT;
         fire_q <= 1'b0;
      end else begin
         fire_q <= 1'b0;
         if (restart) begin
            pre_q <= '0;
            cnt_q <= reload;
         end else if (run) begin
            if (tick) begin
               pre_q <= '0;
               if (cnt_q == '0) begin
                  cnt_q  <= reload;
                  fire_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end
      end
   end

   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !expire);  // R7

   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !expire);  // R9

   AST_FIRE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart && tick && cnt_q == '0) |=> (expire && cnt_q == $past(reload)));  // R8

endmodule

// File: rtl/wdg_lockbank.sv
module wdg_lockbank #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 16,
   parameter logic [CNT_W-1:0] RELOAD_INIT = '1,
   parameter logic [PRE_W-1:0] PRESC_INIT  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdog_rst
);
   import wdg_pkg::*;

   localparam int NG = NUM_GUARDS;

   generate
      if (DATA_W < 16) begin : g_bad_data
         $error("wdg_lockbank: DATA_W must hold a 16-bit key");
      end
      if (CNT_W > DATA_W || PRE_W > DATA_W) begin : g_bad_cnt
         $error("wdg_lockbank: counter fields must fit in DATA_W");
      end
   endgenerate

   logic [NG-1:0] lock_wr, guard_wr, accept, is_open;
   logic [1:0]    prog [NG];

   genvar g;
   generate
      for (g = 0; g < NG; g++) begin : g_gate
         assign lock_wr[g]  = bus_wr && !bus_addr[2] && (bus_addr[1:0] == 2'(g));
         assign guard_wr[g] = bus_wr &&  bus_addr[2] && (bus_addr[1:0] == 2'(g));
         wdg_key_gate #(
            .DATA_W  (DATA_W),
            .NUM_KEYS(nkeys_of(g)),
            .KEY0    (DATA_W'(key_of(g, 0))),
            .KEY1    (DATA_W'(key_of(g, 1))),
            .KEY2    (DATA_W'(key_of(g, 2)))
         ) i_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .lock_wr (lock_wr[g]),
            .guard_wr(guard_wr[g]),
            .wdata   (bus_wdata),
            .accept  (accept[g]),
            .is_open (is_open[g]),
            .prog    (prog[g])
         );
      end
   endgenerate

   logic [CNT_W-1:0] reload_q;
   logic [PRE_W-1:0] presc_q;
   logic             run_q;
   logic             kick_hit, start_hit, restart;

   assign kick_hit  = accept[SEL_KICK] && (bus_wdata == DATA_W'(1));
   assign start_hit = accept[SEL_RUN]  && bus_wdata[0];
   assign restart   = kick_hit || start_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= RELOAD_INIT;
         presc_q  <= PRESC_INIT;
         run_q    <= 1'b0;
      end else begin
         if (accept[SEL_RELOAD]) reload_q <= bus_wdata[CNT_W-1:0];
         if (accept[SEL_PRESC])  presc_q  <= bus_wdata[PRE_W-1:0];
         if (accept[SEL_RUN])    run_q    <= bus_wdata[0];
      end
   end

   wdg_timer #(
      .CNT_W      (CNT_W),
      .PRE_W      (PRE_W),
      .RELOAD_INIT(RELOAD_INIT)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q),
      .restart(restart),
      .reload (reload_q),
      .presc  (presc_q),
      .expire (wdog_rst)
   );

   always_comb begin
      bus_rdata = '0;
      if (!bus_addr[2]) begin
         bus_rdata[1:0] = prog[bus_addr[1:0]];
      end else begin
         case (bus_addr[1:0])
            2'd1:    bus_rdata = DATA_W'(reload_q);
            2'd2:    bus_rdata = DATA_W'(presc_q);
            2'd3:    bus_rdata = DATA_W'(run_q);
            default: bus_rdata = '0;
         endcase
      end
   end

   AST_RELOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_wr[SEL_RELOAD] && !is_open[SEL_RELOAD]) |=> $stable(reload_q));  // R5

   AST_PRESC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_wr[SEL_PRESC] && !is_open[SEL_PRESC]) |=> $stable(presc_q));  // R5

   AST_RUN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_wr[SEL_RUN] && !is_open[SEL_RUN]) |=> $stable(run_q));  // R7

   AST_ONE_GATE_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(accept));  // R2

endmodule

// File: tb/test_wdg_lockbank.sv
module test_wdg_lockbank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        wdog_rst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   wdg_lockbank i_wdg_lockbank (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .wdog_rst (wdog_rst)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // caller is just after a falling edge; consumes exactly one rising edge
   task automatic bw(input logic [2:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
      logic [15:0] v;
      rd(a, v);
      chk(v == exp, req, v, exp);
   endtask

   task automatic t_reset;
      rd_chk(3'd0, 16'h0, "R1 kick lock");
      rd_chk(3'd3, 16'h0, "R1 run lock");
      rd_chk(3'd5, 16'hFFFF, "R1 reload");
      rd_chk(3'd6, 16'h0, "R1 prescale");
      rd_chk(3'd7, 16'h0, "R1 run");
      rd_chk(3'd4, 16'h0, "R1 kick reg");
      chk(wdog_rst == 1'b0, "R1 wdog_rst", wdog_rst, 0);
   endtask

   task automatic t_ignored;
      bw(3'd5, 16'h1234);
      rd_chk(3'd5, 16'hFFFF, "R5 reload locked");
      bw(3'd1, 16'h6666);
      bw(3'd5, 16'h4321);
      rd_chk(3'd5, 16'hFFFF, "R5 reload half open");
      rd_chk(3'd1, 16'h1, "R5 lock progress kept");
      bw(3'd1, 16'h0000);
      rd_chk(3'd1, 16'h0, "R4 bad second key");
   endtask

   task automatic t_progress;
      bw(3'd0, 16'h5555); rd_chk(3'd0, 16'h1, "R2 kick first key");
      bw(3'd0, 16'hAAAA); rd_chk(3'd0, 16'h3, "R2 kick open");
      bw(3'd4, 16'h0000); rd_chk(3'd0, 16'h0, "R6 kick consumed");
      bw(3'd3, 16'h7777); rd_chk(3'd3, 16'h1, "R3 run first key");
      bw(3'd3, 16'hCCCC); rd_chk(3'd3, 16'h2, "R3 run second key");
      bw(3'd3, 16'hDDDD); rd_chk(3'd3, 16'h3, "R3 run open");
      bw(3'd3, 16'h7777); rd_chk(3'd3, 16'h0, "R4 write to open lock");
      bw(3'd3, 16'hCCCC); rd_chk(3'd3, 16'h0, "R4 out of order");
      rd_chk(3'd7, 16'h0, "R5 run untouched");
   endtask

   task automatic t_one_write;
      bw(3'd1, 16'h6666); bw(3'd1, 16'hBBBB);
      rd_chk(3'd1, 16'h3, "R2 reload open");
      bw(3'd5, 16'h0005);
      rd_chk(3'd5, 16'h0005, "R6 reload written");
      rd_chk(3'd1, 16'h0, "R6 reload lock closed");
      bw(3'd5, 16'h0009);
      rd_chk(3'd5, 16'h0005, "R6 second write ignored");
      bw(3'd2, 16'h5A5A); rd_chk(3'd2, 16'h1, "R2 prescale first key");
      bw(3'd2, 16'hA5A5); rd_chk(3'd2, 16'h3, "R2 prescale open");
      bw(3'd6, 16'h0001);
      rd_chk(3'd6, 16'h0001, "R2 prescale written");
   endtask

   task automatic start_run(input logic [15:0] v);
      bw(3'd3, 16'h7777); bw(3'd3, 16'hCCCC); bw(3'd3, 16'hDDDD);
      bw(3'd7, v);
   endtask

   // period with reload 5, prescale 1 is 12 edges
   task automatic t_expiry;
      int seen;
      start_run(16'h0001);
      rd_chk(3'd7, 16'h1, "R7 running");
      seen = 0;
      for (int i = 1; i <= 11; i++) begin @(negedge clk); seen += int'(wdog_rst); end
      chk(seen == 0, "R8 quiet before expiry", seen, 0);
      @(negedge clk); chk(wdog_rst == 1'b1, "R8 pulse at edge 12", wdog_rst, 1);
      @(negedge clk); chk(wdog_rst == 1'b0, "R8 one cycle pulse", wdog_rst, 0);
      seen = 0;
      for (int i = 14; i <= 23; i++) begin @(negedge clk); seen += int'(wdog_rst); end
      chk(seen == 0, "R8 quiet in second period", seen, 0);
      @(negedge clk); chk(wdog_rst == 1'b1, "R8 pulse at edge 24", wdog_rst, 1);
   endtask

   task automatic t_kick_collide;
      int seen;
      start_run(16'h0001);
      bw(3'd0, 16'h5555); bw(3'd0, 16'hAAAA);
      seen = 0;
      for (int i = 3; i <= 11; i++) begin @(negedge clk); seen += int'(wdog_rst); end
      chk(seen == 0, "R9 quiet before kick", seen, 0);
      bw(3'd4, 16'h0001);
      chk(wdog_rst == 1'b0, "R9 kick beats expiry", wdog_rst, 0);
      seen = 0;
      for (int i = 13; i <= 23; i++) begin @(negedge clk); seen += int'(wdog_rst); end
      chk(seen == 0, "R9 quiet after kick", seen, 0);
      @(negedge clk); chk(wdog_rst == 1'b1, "R9 pulse one period after kick", wdog_rst, 1);
   endtask

   task automatic t_stop;
      int seen;
      start_run(16'h0000);
      rd_chk(3'd7, 16'h0, "R7 stopped");
      seen = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); seen += int'(wdog_rst); end
      chk(seen == 0, "R7 no pulse while stopped", seen, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ignored();
      t_progress();
      t_one_write();
      t_expiry();
      t_kick_collide();
      t_stop();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule